// File: doc/BRIEF.md
# Twelve-to-Sixteen Bit Word Packer

The block packs a stream of 12-bit words into 16-bit words with no padding bits, so four input words become exactly three output words. A 28-bit staging register holds the data. Its upper 12 bits are the zone where each new input word is loaded, and its lower 16 bits are the zone where finished output words are read. On every clock the register moves its contents down by 4 bits. With that fixed step, a word slot opens every 3 clocks and a completed output word lines up at the bottom every 4 clocks. No barrel shifter is needed.

The interface runs at a fixed rate. The block raises `in_ready_o` on the clocks where it takes a word, and the source must present a word or a flush request on each of those clocks. The source drives `flush_i` in a slot instead of data to end the stream. Any residual bits then come out as one last word, zero-filled at the top. After that the block starts a new stream, aligned to a group boundary.

Top module: `word_packer`

## Requirements
- R1: While `rst_ni` is low, and on the first clock after it rises, `in_ready_o` is 1, `out_valid_o` is 0 and `out_data_o` is 0. After a reset in mid-stream, packing starts afresh: the first word taken after reset supplies the low 12 bits of the next output word.
- R2: While a stream is running, `in_ready_o` is high on exactly one clock in every three. A word is taken only on a clock where `in_ready_o` is high.
- R3: Bits pack lowest first. With inputs a, b, c, d taken in that order, the outputs are {b[3:0], a[11:0]}, then {c[7:0], b[11:4]}, then {d[11:0], c[11:8]}, and the pattern repeats for every four inputs.
- R4: When a word is taken on a clock while the block holds no pending bits, the first output word built from it has `out_valid_o` high 5 clocks later.
- R5: `out_valid_o` is high on one clock, and the next output follows 4 clocks later. Consecutive output words are always 4 clocks apart.
- R6: `out_data_o` is 0 on every clock where `out_valid_o` is low.
- R7: On clocks where `in_ready_o` is low, `in_data_i` and `flush_i` have no effect on the output words.
- R8: `flush_i` high on a clock where `in_ready_o` is high uses that slot and takes no data. The block still emits every complete word, then emits the residual bits as one final word with zeros above them. After one, two or three words of a group, that final word is {4'h0, a}, {8'h00, b[11:4]} or {12'h000, c[11:8]}.
- R9: After a flush, `in_ready_o` stays low until the final output word has left. It rises 2 clocks after that word. The next stream packs from a fresh group, as in R3.
- R10: A flush while no bits are pending emits no output word, and `in_ready_o` rises again 2 clocks after the flush clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_data_i | input | 12 | Input word, taken when `in_ready_o` is high and `flush_i` is low |
| flush_i | input | 1 | End of stream, sampled only when `in_ready_o` is high |
| in_ready_o | output | 1 | Input slot strobe |
| out_data_o | output | 16 | Packed output word, 0 when not valid |
| out_valid_o | output | 1 | Output word strobe |

## Verification
A fault in the fill counters or the slot counter shows up first as timing. The first output word arrives at some clock other than 5 clocks after the first word is taken, or outputs come at a spacing other than 4 clocks. Either error is visible within one 12-clock group. A fault in the staging register shows up as a wrong nibble in the first output word of a group, since the bench gives every nibble of the stream a distinct value. A fault in the drain logic shows up around a flush: an extra or missing final word, padding bits that are not zero, or `in_ready_o` returning at the wrong clock after the final word.

// File: rtl/wp_pkg.sv
package wp_pkg;

  function automatic int unsigned gcd_f(input int unsigned a, input int unsigned b);
    int unsigned x;
    int unsigned y;
    int unsigned t;
    x = a;
    y = b;
    while (y != 0) begin
      t = x % y;
      x = y;
      y = t;
    end
    return x;
  endfunction

  function automatic int unsigned cnt_width_f(input int unsigned max_val);
    return (max_val > 1) ? $clog2(max_val + 1) : 1;
  endfunction

endpackage

// File: rtl/wp_cadence.sv
module wp_cadence
  import wp_pkg::*;
#(
  parameter int unsigned SLOT_PERIOD = 3,
  parameter int unsigned GROUP_WORDS = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic flush_i,
  input  logic empty_i,
  output logic in_ready_o,
  output logic load_o,
  output logic group_start_o
);

  localparam int unsigned SLOT_W = cnt_width_f(SLOT_PERIOD - 1);
  localparam int unsigned PH_W   = cnt_width_f(GROUP_WORDS - 1);
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(SLOT_PERIOD - 1);
  localparam logic [PH_W-1:0]   PH_LAST   = PH_W'(GROUP_WORDS - 1);

  logic [SLOT_W-1:0] slot_q;
  logic [PH_W-1:0]   phase_q;
  logic              drain_q;
  logic              take_flush;

  assign in_ready_o    = !drain_q && (slot_q == '0);
  assign load_o        = in_ready_o && !flush_i;
  assign take_flush    = in_ready_o && flush_i;
  assign group_start_o = (phase_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q  <= '0;
      phase_q <= '0;
      drain_q <= 1'b0;
    end else if (drain_q) begin
      slot_q <= '0;
      if (empty_i) begin
        // residue gone: restart on a group boundary
        drain_q <= 1'b0;
        phase_q <= '0;
      end
    end else begin
      slot_q <= (slot_q == SLOT_LAST) ? '0 : slot_q + 1'b1;
      if (take_flush) drain_q <= 1'b1;
      if (load_o) phase_q <= (phase_q == PH_LAST) ? '0 : phase_q + 1'b1;
    end
  end

  AST_READY_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ready_o |=> !in_ready_o); // R2

endmodule

// File: rtl/wp_track.sv
module wp_track
  import wp_pkg::*;
#(
  parameter int unsigned TOT_U = 7,
  parameter int unsigned OUT_U = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic empty_o,
  output logic emit_o,
  output logic [cnt_width_f(TOT_U)-1:0] hi_o,
  output logic [cnt_width_f(TOT_U)-1:0] lo_o
);

  localparam int unsigned CNT_W = cnt_width_f(TOT_U);
  localparam logic [CNT_W-1:0] HI_FULL  = CNT_W'(TOT_U);
  localparam logic [CNT_W-1:0] LO_ENTRY = CNT_W'(OUT_U);
  localparam logic [CNT_W-1:0] LO_NEXT  = CNT_W'(OUT_U - 1);

  // positions in step units: hi = top of pending data, lo = next unsent bit
  logic [CNT_W-1:0] hi_q;
  logic [CNT_W-1:0] lo_q;

  assign empty_o = (hi_q <= lo_q);
  assign emit_o  = (lo_q == '0) && !empty_o;
  assign hi_o    = hi_q;
  assign lo_o    = lo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (load_i) begin
      hi_q <= HI_FULL;
      if (empty_o)           lo_q <= LO_ENTRY;
      else if (lo_q == '0)   lo_q <= LO_NEXT;
      else                   lo_q <= lo_q - 1'b1;
    end else if (empty_o) begin
      hi_q <= '0;
      lo_q <= '0;
    end else begin
      hi_q <= hi_q - 1'b1;
      lo_q <= (lo_q == '0) ? LO_NEXT : lo_q - 1'b1;
    end
  end

  AST_NO_OVERWRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !empty_o) |-> (hi_q <= CNT_W'(OUT_U + 1))); // R3

  AST_EMIT_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    emit_o |=> !emit_o); // R5

endmodule

// File: rtl/wp_stage.sv
module wp_stage #(
  parameter int unsigned IN_W  = 12,
  parameter int unsigned OUT_W = 16,
  parameter int unsigned STEP  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [IN_W-1:0]  in_data_i,
  output logic [OUT_W-1:0] word_o
);

  localparam int unsigned TOT_W = IN_W + OUT_W;

  logic [TOT_W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q <= '0;
    end else if (load_i) begin
      // top zone is free after this step; new word lands right above the stream
      sr_q <= {in_data_i, sr_q[OUT_W+STEP-1:STEP]};
    end else begin
      sr_q <= {{STEP{1'b0}}, sr_q[TOT_W-1:STEP]};
    end
  end

  assign word_o = sr_q[OUT_W-1:0];

endmodule

// File: rtl/word_packer.sv
module word_packer
  import wp_pkg::*;
#(
  parameter int unsigned IN_W  = 12,
  parameter int unsigned OUT_W = 16,
  parameter int unsigned STEP  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IN_W-1:0]  in_data_i,
  input  logic             flush_i,
  output logic             in_ready_o,
  output logic [OUT_W-1:0] out_data_o,
  output logic             out_valid_o
);

  localparam int unsigned IN_U        = IN_W / STEP;
  localparam int unsigned OUT_U       = OUT_W / STEP;
  localparam int unsigned TOT_U       = IN_U + OUT_U;
  localparam int unsigned GROUP_WORDS = OUT_W / gcd_f(IN_W, OUT_W);
  localparam int unsigned CNT_W       = cnt_width_f(TOT_U);

  logic             load;
  logic             empty;
  logic             emit;
  logic             group_start;
  logic [CNT_W-1:0] hi;
  logic [CNT_W-1:0] lo;
  logic [OUT_W-1:0] word;

  wp_cadence #(
    .SLOT_PERIOD (IN_U),
    .GROUP_WORDS (GROUP_WORDS)
  ) i_cadence (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .flush_i       (flush_i),
    .empty_i       (empty),
    .in_ready_o    (in_ready_o),
    .load_o        (load),
    .group_start_o (group_start)
  );

  wp_track #(
    .TOT_U (TOT_U),
    .OUT_U (OUT_U)
  ) i_track (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .empty_o (empty),
    .emit_o  (emit),
    .hi_o    (hi),
    .lo_o    (lo)
  );

  wp_stage #(
    .IN_W  (IN_W),
    .OUT_W (OUT_W),
    .STEP  (STEP)
  ) i_stage (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .in_data_i (in_data_i),
    .word_o    (word)
  );

  assign out_valid_o = emit;
  assign out_data_o  = emit ? word : '0;

  // a new group starts with only the tail of the previous group's last word pending
  AST_GROUP_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load && group_start && !empty) |-> ((lo == CNT_W'(1)) && (hi == CNT_W'(OUT_U + 1)))); // R9

  AST_PAD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> ((32'(out_data_o) >> (int'(hi) * STEP)) == 32'd0)); // R8

endmodule

// File: tb/test_word_packer.sv
module test_word_packer;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [11:0] in_data_i = '0;
  logic        flush_i = 1'b0;
  logic        in_ready_o;
  logic [15:0] out_data_o;
  logic        out_valid_o;

  int n_chk = 0;
  int n_fail = 0;

  // nibble stream 1,2,3,...,F,0,1,... spread over 12-bit inputs
  localparam logic [11:0] IN_TAB [8] = '{12'h321, 12'h654, 12'h987, 12'hCBA,
                                         12'hFED, 12'h210, 12'h543, 12'h876};
  localparam logic [15:0] OUT_TAB [6] = '{16'h4321, 16'h8765, 16'hCBA9,
                                          16'h0FED, 16'h4321, 16'h8765};

  always #10 clk_i = ~clk_i;

  word_packer i_word_packer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_data_i   (in_data_i),
    .flush_i     (flush_i),
    .in_ready_o  (in_ready_o),
    .out_data_o  (out_data_o),
    .out_valid_o (out_valid_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_word(input int j, input int n);
    int bits;
    int full;
    bits = 12 * n;
    full = bits / 16;
    if (j < full) return OUT_TAB[j];
    return OUT_TAB[j] & 16'((1 << (bits % 16)) - 1);
  endfunction

  // entered and left at a falling edge where in_ready_o is high
  task automatic run_case(input int n);
    int  cyc = 0;
    int  idx = 0;
    int  nout = 0;
    int  first_acc = -1;
    int  prev_v = -1;
    int  prev_r = -1;
    int  flush_cyc = -1;
    int  exp_n;
    bit  flushed = 0;
    bit  done = 0;
    bit  idle_bad = 0;
    bit  ready_bad = 0;
    exp_n = (12 * n + 15) / 16;
    while (!done && cyc < 200) begin
      if (out_valid_o) begin
        if (nout < exp_n)
          chk(out_data_o == exp_word(nout, n), "R3 R7 R8", $sformatf("n=%0d word %0d", n, nout),
              int'(out_data_o), int'(exp_word(nout, n)));
        else
          chk(1'b0, "R8 R10", $sformatf("n=%0d extra word", n), int'(out_data_o), 0);
        if (nout == 0)
          chk(cyc - first_acc == 5, "R4", $sformatf("n=%0d first word latency", n),
              cyc - first_acc, 5);
        else
          chk(cyc - prev_v == 4, "R5", $sformatf("n=%0d output spacing", n), cyc - prev_v, 4);
        prev_v = cyc;
        nout++;
      end else if (out_data_o != 16'h0) begin
        idle_bad = 1;
      end
      if (in_ready_o) begin
        if (flushed) begin
          done = 1;
        end else begin
          if (prev_r >= 0 && cyc - prev_r != 3) ready_bad = 1;
          prev_r = cyc;
          if (idx < n) begin
            in_data_i = IN_TAB[idx];
            flush_i   = 1'b0;
            if (first_acc < 0) first_acc = cyc;
            idx++;
          end else begin
            in_data_i = 12'hFFF;
            flush_i   = 1'b1;
            flushed   = 1;
            flush_cyc = cyc;
          end
        end
      end else begin
        // junk outside slots must be ignored
        in_data_i = 12'(cyc * 12'h5A7);
        flush_i   = 1'b1;
      end
      if (!done) begin
        @(negedge clk_i);
        cyc++;
      end
    end
    chk(done, "R9", $sformatf("n=%0d stream restart seen", n), int'(done), 1);
    chk(nout == exp_n, (n == 0) ? "R10" : "R8", $sformatf("n=%0d word count", n), nout, exp_n);
    if (n == 0)
      chk(cyc - flush_cyc == 2, "R10", "ready return after empty flush", cyc - flush_cyc, 2);
    else
      chk(cyc - prev_v == 2, "R9", $sformatf("n=%0d ready return after last word", n),
          cyc - prev_v, 2);
    chk(!idle_bad, "R6", $sformatf("n=%0d data zero while not valid", n), int'(idle_bad), 0);
    chk(!ready_bad, "R2", $sformatf("n=%0d slot spacing", n), int'(ready_bad), 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(in_ready_o == 1'b1, "R1", "ready in reset", int'(in_ready_o), 1);
    chk(out_valid_o == 1'b0, "R1", "valid in reset", int'(out_valid_o), 0);
    chk(out_data_o == 16'h0, "R1", "data in reset", int'(out_data_o), 0);
    rst_ni = 1'b1;
    #1;
    chk(in_ready_o == 1'b1, "R1", "ready after release", int'(in_ready_o), 1);

    run_case(0);
    run_case(8);
    run_case(1);
    run_case(2);
    run_case(3);
    run_case(5);
    run_case(4);

    // reset in mid-stream, then a fresh stream must pack from its own first word
    for (int i = 0; i < 5; i++) begin
      in_data_i = 12'hA5A;
      flush_i   = 1'b0;
      @(negedge clk_i);
    end
    rst_ni = 1'b0;
    #1;
    chk(out_valid_o == 1'b0, "R1", "valid in mid-stream reset", int'(out_valid_o), 0);
    chk(in_ready_o == 1'b1, "R1", "ready in mid-stream reset", int'(in_ready_o), 1);
    @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    chk(in_ready_o == 1'b1, "R1", "ready after mid-stream reset", int'(in_ready_o), 1);
    run_case(3);
    run_case(8);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule